// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block runs a small program of command words that software places in a register array. Each word names one bus action: repeated start, write some bytes, read some bytes, stop, or end. It also carries a byte count and three bits that control the acknowledge slot. A pulse on `go` starts the program. The sequencer walks the entries in order and turns each one into single-bit requests for a separate bus timing generator. It marks every entry it completes and emits one-cycle event pulses that an interrupt block can collect.

Write bytes come in on a valid/ready stream from a transmit FIFO. The sequencer raises `tx_ready` only while it waits for the next byte to send. If `tx_valid` stays low, the sequencer simply waits and issues no bus request. Received bytes go out on a valid/ready stream to a receive FIFO. A byte on `rx_data` stays stable with `rx_valid` high until `rx_ready` accepts it. No bus request is issued during that time, so back-pressure from the FIFO stalls the bus rather than dropping data.

The bus timing generator sees one request at a time. `bus_req` stays high with `bus_op` and `bus_wbit` stable until a one-cycle `bus_done` arrives. That same cycle also carries the sampled line level on `bus_rbit` and, if control of the bus was lost, `bus_lost`. Bus op codes are: 0 start, 1 stop, 2 write bit, 3 read bit.

Top module: `i2cseq_master`

## Requirements
- R1: A command word is opcode in bits 13:11, ACK-value in bit 10, expected-ACK in bit 9, ACK-check-enable in bit 8 and byte count in bits 7:0. Opcodes are 0 restart, 1 write, 2 read, 3 stop, 4 end. A `go` pulse while idle starts a run at entry 0 unless a resume point is pending. A `go` pulse while busy is ignored.
- R2: A restart entry issues one start request (op 0). On its completion the sequencer pulses `ev_start`.
- R3: A write entry does the following for each byte:
  - It takes the byte from the TX stream; `tx_ready` is high only while it waits for that byte.
  - It issues eight write-bit requests (op 2), bit 0 first when `tx_lsb_first` is 1 and bit 7 first otherwise.
  - It then issues one read request (op 3) for the ACK slot and pulses `ev_byte`.
- R4: A read entry does the following for each byte:
  - It issues eight read requests and assembles the bits, with the first bit landing in bit 0 when `rx_lsb_first` is 1 and in bit 7 otherwise.
  - It offers the byte on the RX stream and holds it until accepted, issuing no bus request meanwhile.
  - It then issues a write request carrying the entry's ACK-value bit and pulses `ev_byte`.
- R5: A write or read entry with a byte count of 0 completes without any bus request or stream transfer.
- R6: `cmd_done[i]` is set when entry i completes. It is cleared when software writes entry i and when a run starts from entry 0.
- R7: A stop entry issues a stop request (op 1). On completion it pulses `ev_stop_done` and ends the run, and the next `go` starts at entry 0.
- R8: An end entry, or an entry with an opcode of 5 to 7, completes at once, pulses `ev_end` and returns to idle. The next `go` resumes at the following entry and keeps the existing done flags.
- R9: ACK checking works as follows:
  - When ACK checking is enabled and the ACK bit read after a written byte differs from expected-ACK, the sequencer pulses `ev_ack_err` together with `ev_byte`.
  - The entry is left not done.
  - A stop request is issued if a start was sent earlier, and the sequencer then goes idle.
  - With checking disabled, the mismatch has no effect.
- R10: A `bus_done` with `bus_lost` high pulses `ev_arb_lost` and returns the sequencer to idle without a stop request.
- R11: Once issued, `bus_req` stays high with `bus_op` and `bus_wbit` unchanged until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command array |
| cmd_widx | input | IDX_W | Entry index written |
| cmd_wdata | input | 14 | Command word written |
| cmd_done | output | N_CMDS | Per-entry completion flags |
| go | input | 1 | Start or resume pulse |
| tx_lsb_first | input | 1 | Send order: 1 bit 0 first |
| rx_lsb_first | input | 1 | Receive order: 1 first bit into bit 0 |
| busy | output | 1 | A run is in progress |
| tx_valid | input | 1 | TX stream byte available |
| tx_ready | output | 1 | TX stream byte taken |
| tx_data | input | DATA_W | TX stream byte |
| rx_valid | output | 1 | RX stream byte offered |
| rx_ready | input | 1 | RX stream accepts byte |
| rx_data | output | DATA_W | RX stream byte |
| bus_req | output | 1 | Bit-level request pending |
| bus_op | output | 2 | 0 start, 1 stop, 2 write bit, 3 read bit |
| bus_wbit | output | 1 | Level to drive for a write-bit request |
| bus_done | input | 1 | Request completed (one cycle) |
| bus_rbit | input | 1 | Sampled level for a read request |
| bus_lost | input | 1 | Bus control lost, valid with bus_done |
| ev_start | output | 1 | Start issued pulse |
| ev_byte | output | 1 | Byte sent or received pulse |
| ev_ack_err | output | 1 | ACK mismatch pulse |
| ev_arb_lost | output | 1 | Bus control lost pulse |
| ev_stop_done | output | 1 | Stop entry finished pulse |
| ev_end | output | 1 | End entry finished pulse |

## Verification
The bench builds the block with its default sizes: sixteen entries and eight-bit bytes. At these sizes both bit orders, every opcode, resumption after an end entry and the done flags of a full program are all within reach in short runs. A responder in the bench plays the timing generator. It answers each request, feeds slave bits, and can report a lost bus on a chosen request. The bench also stalls both streams so that hold-off and back-pressure are exercised.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int CMD_W = 14;
  localparam int CNT_W = 8;

  localparam logic [2:0] OPC_RSTART = 3'd0;
  localparam logic [2:0] OPC_WRITE  = 3'd1;
  localparam logic [2:0] OPC_READ   = 3'd2;
  localparam logic [2:0] OPC_STOP   = 3'd3;
  localparam logic [2:0] OPC_END    = 3'd4;

  typedef struct packed {
    logic [2:0]       opc;
    logic             ack_val;
    logic             ack_exp;
    logic             ack_chk;
    logic [CNT_W-1:0] cnt;
  } cmd_t;

  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_STOP  = 2'd1,
    BOP_WRITE = 2'd2,
    BOP_READ  = 2'd3
  } bus_op_e;
endpackage

// File: rtl/i2cseq_cmd_store.sv
module i2cseq_cmd_store
  import i2cseq_pkg::*;
#(
  parameter int N_CMDS = 16,
  parameter int IDX_W  = $clog2(N_CMDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  cmd_t              wr_cmd,
  input  logic [IDX_W-1:0]  rd_idx,
  output cmd_t              rd_cmd,
  input  logic              done_set,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              done_clr_all,
  output logic [N_CMDS-1:0] done_flags
);
  cmd_t entry_q [N_CMDS];

  for (genvar gi = 0; gi < N_CMDS; gi++) begin : g_entry
    logic hit_wr;
    logic hit_done;
    assign hit_wr   = wr_en && (wr_idx == IDX_W'(gi));
    assign hit_done = done_set && (done_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[gi]    <= '0;
        done_flags[gi] <= 1'b0;
      end else begin
        if (hit_wr) entry_q[gi] <= wr_cmd;
        if (hit_wr || done_clr_all) done_flags[gi] <= 1'b0;
        else if (hit_done)          done_flags[gi] <= 1'b1;
      end
    end
  end

  assign rd_cmd = entry_q[rd_idx];
endmodule

// File: rtl/i2cseq_shifter.sv
module i2cseq_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              adv_out,
  input  logic              cap_in,
  input  logic              cap_bit,
  input  logic              tx_lsb,
  input  logic              rx_lsb,
  output logic              out_bit,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= load_data;
    end else if (adv_out) begin
      data_q <= tx_lsb ? (data_q >> 1) : (data_q << 1);
    end else if (cap_in) begin
      data_q <= rx_lsb ? {cap_bit, data_q[DATA_W-1:1]}
                       : {data_q[DATA_W-2:0], cap_bit};
    end
  end

  assign out_bit = tx_lsb ? data_q[0] : data_q[DATA_W-1];
endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
  import i2cseq_pkg::*;
#(
  parameter int N_CMDS = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(N_CMDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic [IDX_W-1:0] pc,
  input  cmd_t             cur_cmd,
  output logic             done_set,
  output logic             done_clr_all,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             sh_load,
  output logic             sh_adv,
  output logic             sh_cap,
  input  logic             sh_out_bit,
  output logic             bus_req,
  output logic [1:0]       bus_op,
  output logic             bus_wbit,
  input  logic             bus_done,
  input  logic             bus_rbit,
  input  logic             bus_lost,
  output logic             ev_start,
  output logic             ev_byte,
  output logic             ev_ack_err,
  output logic             ev_arb_lost,
  output logic             ev_stop_done,
  output logic             ev_end
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CMDS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_START, S_TXWAIT, S_WBIT, S_WACK,
    S_RBIT, S_RXPUSH, S_RACK, S_STOP, S_ABORT
  } state_e;

  state_e           state_q;
  cmd_t             cmd_q;
  logic [CNT_W-1:0] left_q;
  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] resume_pc_q;
  logic             resume_q;
  logic             owns_q;

  logic fetch_end, fetch_empty, step_done, lost_now, ack_bad, advance;

  assign busy     = (state_q != S_IDLE);
  assign lost_now = bus_req && bus_done && bus_lost;
  assign ack_bad  = cmd_q.ack_chk && (bus_rbit != cmd_q.ack_exp);

  assign fetch_end   = (state_q == S_FETCH) &&
                       !(cur_cmd.opc inside {OPC_RSTART, OPC_WRITE, OPC_READ, OPC_STOP});
  assign fetch_empty = (state_q == S_FETCH) &&
                       (cur_cmd.opc inside {OPC_WRITE, OPC_READ}) && (cur_cmd.cnt == '0);

  // Normal completion of a bus step that also finishes the current entry.
  always_comb begin
    step_done = 1'b0;
    if (bus_done && !bus_lost) begin
      unique case (state_q)
        S_START: step_done = 1'b1;
        S_STOP:  step_done = 1'b1;
        S_WACK:  step_done = !ack_bad && (left_q == CNT_W'(1));
        S_RACK:  step_done = (left_q == CNT_W'(1));
        default: step_done = 1'b0;
      endcase
    end
  end

  assign done_set     = fetch_end || fetch_empty || step_done;
  assign advance      = fetch_empty || (step_done && state_q != S_STOP);
  assign done_clr_all = go && !busy && !resume_q;

  always_comb begin
    bus_req  = 1'b0;
    bus_op   = BOP_START;
    bus_wbit = 1'b0;
    unique case (state_q)
      S_START: bus_req = 1'b1;
      S_STOP:  begin bus_req = 1'b1; bus_op = BOP_STOP; end
      S_ABORT: begin bus_req = owns_q; bus_op = BOP_STOP; end
      S_WBIT:  begin bus_req = 1'b1; bus_op = BOP_WRITE; bus_wbit = sh_out_bit; end
      S_WACK:  begin bus_req = 1'b1; bus_op = BOP_READ; end
      S_RBIT:  begin bus_req = 1'b1; bus_op = BOP_READ; end
      S_RACK:  begin bus_req = 1'b1; bus_op = BOP_WRITE; bus_wbit = cmd_q.ack_val; end
      default: bus_req = 1'b0;
    endcase
  end

  assign tx_ready = (state_q == S_TXWAIT);
  assign rx_valid = (state_q == S_RXPUSH);
  assign sh_load  = tx_ready && tx_valid;
  assign sh_adv   = (state_q == S_WBIT) && bus_done && !bus_lost;
  assign sh_cap   = (state_q == S_RBIT) && bus_done && !bus_lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      cmd_q        <= '0;
      left_q       <= '0;
      bit_q        <= '0;
      pc           <= '0;
      resume_pc_q  <= '0;
      resume_q     <= 1'b0;
      owns_q       <= 1'b0;
      ev_start     <= 1'b0;
      ev_byte      <= 1'b0;
      ev_ack_err   <= 1'b0;
      ev_arb_lost  <= 1'b0;
      ev_stop_done <= 1'b0;
      ev_end       <= 1'b0;
    end else begin
      ev_start     <= 1'b0;
      ev_byte      <= 1'b0;
      ev_ack_err   <= 1'b0;
      ev_arb_lost  <= 1'b0;
      ev_stop_done <= 1'b0;
      ev_end       <= 1'b0;

      if (lost_now) begin
        ev_arb_lost <= 1'b1;
        owns_q      <= 1'b0;
        resume_q    <= 1'b0;
        state_q     <= S_IDLE;
      end else if (advance) begin
        if (pc == LAST_IDX) begin
          resume_q <= 1'b0;
          state_q  <= S_IDLE;
        end else begin
          pc      <= pc + 1'b1;
          state_q <= S_FETCH;
        end
        if (state_q == S_START) begin
          ev_start <= 1'b1;
          owns_q   <= 1'b1;
        end
        if (state_q == S_WACK || state_q == S_RACK) ev_byte <= 1'b1;
      end else begin
        unique case (state_q)
          S_IDLE: if (go) begin
            pc       <= resume_q ? resume_pc_q : '0;
            resume_q <= 1'b0;
            state_q  <= S_FETCH;
          end
          S_FETCH: begin
            cmd_q  <= cur_cmd;
            left_q <= cur_cmd.cnt;
            bit_q  <= '0;
            unique case (cur_cmd.opc)
              OPC_RSTART: state_q <= S_START;
              OPC_WRITE:  state_q <= S_TXWAIT;
              OPC_READ:   state_q <= S_RBIT;
              OPC_STOP:   state_q <= S_STOP;
              default: begin
                ev_end      <= 1'b1;
                resume_q    <= 1'b1;
                resume_pc_q <= pc + 1'b1;
                state_q     <= S_IDLE;
              end
            endcase
          end
          S_TXWAIT: if (tx_valid) begin
            bit_q   <= '0;
            state_q <= S_WBIT;
          end
          S_WBIT: if (bus_done) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) state_q <= S_WACK;
          end
          S_WACK: if (bus_done) begin
            ev_byte <= 1'b1;
            if (ack_bad) begin
              ev_ack_err <= 1'b1;
              resume_q   <= 1'b0;
              state_q    <= S_ABORT;
            end else begin
              left_q  <= left_q - 1'b1;
              state_q <= S_TXWAIT;
            end
          end
          S_RBIT: if (bus_done) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) state_q <= S_RXPUSH;
          end
          S_RXPUSH: if (rx_ready) state_q <= S_RACK;
          S_RACK: if (bus_done) begin
            ev_byte <= 1'b1;
            left_q  <= left_q - 1'b1;
            bit_q   <= '0;
            state_q <= S_RBIT;
          end
          S_STOP: if (bus_done) begin
            ev_stop_done <= 1'b1;
            owns_q       <= 1'b0;
            resume_q     <= 1'b0;
            state_q      <= S_IDLE;
          end
          S_ABORT: if (!owns_q || bus_done) begin
            owns_q  <= 1'b0;
            state_q <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cseq_master.sv
module i2cseq_master
  import i2cseq_pkg::*;
#(
  parameter int N_CMDS = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(N_CMDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [IDX_W-1:0]  cmd_widx,
  input  logic [13:0]       cmd_wdata,
  output logic [N_CMDS-1:0] cmd_done,
  input  logic              go,
  input  logic              tx_lsb_first,
  input  logic              rx_lsb_first,
  output logic              busy,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic              bus_wbit,
  input  logic              bus_done,
  input  logic              bus_rbit,
  input  logic              bus_lost,
  output logic              ev_start,
  output logic              ev_byte,
  output logic              ev_ack_err,
  output logic              ev_arb_lost,
  output logic              ev_stop_done,
  output logic              ev_end
);
  logic [IDX_W-1:0] pc;
  cmd_t             cur_cmd;
  logic             done_set, done_clr_all;
  logic             sh_load, sh_adv, sh_cap, sh_out_bit;

  i2cseq_cmd_store #(.N_CMDS(N_CMDS), .IDX_W(IDX_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cmd_we),
    .wr_idx       (cmd_widx),
    .wr_cmd       (cmd_t'(cmd_wdata)),
    .rd_idx       (pc),
    .rd_cmd       (cur_cmd),
    .done_set     (done_set),
    .done_idx     (pc),
    .done_clr_all (done_clr_all),
    .done_flags   (cmd_done)
  );

  i2cseq_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sh_load),
    .load_data (tx_data),
    .adv_out   (sh_adv),
    .cap_in    (sh_cap),
    .cap_bit   (bus_rbit),
    .tx_lsb    (tx_lsb_first),
    .rx_lsb    (rx_lsb_first),
    .out_bit   (sh_out_bit),
    .data_q    (rx_data)
  );

  i2cseq_fsm #(.N_CMDS(N_CMDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .busy         (busy),
    .pc           (pc),
    .cur_cmd      (cur_cmd),
    .done_set     (done_set),
    .done_clr_all (done_clr_all),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .sh_load      (sh_load),
    .sh_adv       (sh_adv),
    .sh_cap       (sh_cap),
    .sh_out_bit   (sh_out_bit),
    .bus_req      (bus_req),
    .bus_op       (bus_op),
    .bus_wbit     (bus_wbit),
    .bus_done     (bus_done),
    .bus_rbit     (bus_rbit),
    .bus_lost     (bus_lost),
    .ev_start     (ev_start),
    .ev_byte      (ev_byte),
    .ev_ack_err   (ev_ack_err),
    .ev_arb_lost  (ev_arb_lost),
    .ev_stop_done (ev_stop_done),
    .ev_end       (ev_end)
  );
endmodule

// File: rtl/i2cseq_master_chk.sv
module i2cseq_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              busy,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              bus_req,
  input logic [1:0]        bus_op,
  input logic              bus_wbit,
  input logic              bus_done,
  input logic              bus_lost,
  input logic              ev_byte,
  input logic              ev_ack_err,
  input logic              ev_arb_lost,
  input logic              ev_stop_done,
  input logic              ev_end
);
  // R1
  go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && !busy |=> busy);

  // R3
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !bus_req && !rx_valid);

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && !bus_req);

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_done |-> !busy);

  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |-> !busy);

  // R9
  ack_err_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_err |-> ev_byte);

  // R10
  arb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_done && bus_lost |=> !busy && ev_arb_lost);

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> bus_req && $stable(bus_op) && $stable(bus_wbit));
endmodule

bind i2cseq_master i2cseq_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .go           (go),
  .busy         (busy),
  .tx_ready     (tx_ready),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_data      (rx_data),
  .bus_req      (bus_req),
  .bus_op       (bus_op),
  .bus_wbit     (bus_wbit),
  .bus_done     (bus_done),
  .bus_lost     (bus_lost),
  .ev_byte      (ev_byte),
  .ev_ack_err   (ev_ack_err),
  .ev_arb_lost  (ev_arb_lost),
  .ev_stop_done (ev_stop_done),
  .ev_end       (ev_end)
);

// File: tb/i2cseq_master_bench.sv
module i2cseq_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [3:0] cmd_widx = '0;
  logic [13:0] cmd_wdata = '0;
  logic [N-1:0] cmd_done;
  logic go = 1'b0, tx_lsb_first = 1'b0, rx_lsb_first = 1'b0, busy;
  logic tx_valid = 1'b0, tx_ready;
  logic [DW-1:0] tx_data = '0;
  logic rx_valid, rx_ready = 1'b1;
  logic [DW-1:0] rx_data;
  logic bus_req, bus_wbit;
  logic [1:0] bus_op;
  logic bus_done = 1'b0, bus_rbit = 1'b0, bus_lost = 1'b0;
  logic ev_start, ev_byte, ev_ack_err, ev_arb_lost, ev_stop_done, ev_end;

  i2cseq_master u_i2cseq_master (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  logic [2:0] exp_ops[$];
  logic rbits[$];
  logic [7:0] tx_q[$];
  logic [7:0] rx_exp[$];
  int op_idx = 0, lost_at = -1, tx_stall = 0, rx_stall = 0;
  int n_start = 0, n_byte = 0, n_err = 0, n_arb = 0, n_stop = 0, n_end = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bus responder and scoreboard for bit requests.
  always @(negedge clk) begin
    if (bus_done) begin
      bus_done = 1'b0; bus_lost = 1'b0; bus_rbit = 1'b0;
    end else if (bus_req) begin
      if (exp_ops.size() == 0) chk(0, cur_req, "unexpected bus op", {bus_op, bus_wbit}, 0);
      else begin
        logic [2:0] e;
        e = exp_ops.pop_front();
        chk(e[2:1] == bus_op && (bus_op != 2'd2 || e[0] == bus_wbit),
            cur_req, "bus op", {bus_op, bus_wbit}, e);
      end
      if (bus_op == 2'd3) bus_rbit = (rbits.size() > 0) ? rbits.pop_front() : 1'b1;
      bus_lost = (op_idx == lost_at);
      op_idx++;
      bus_done = 1'b1;
    end
  end

  // TX stream source.
  initial forever begin
    bit fire;
    @(negedge clk);
    fire = tx_valid && tx_ready;
    @(posedge clk); #1;
    if (fire) void'(tx_q.pop_front());
    if (tx_stall > 0) begin tx_valid = 1'b0; tx_stall--; end
    else begin
      tx_valid = (tx_q.size() > 0);
      tx_data  = (tx_q.size() > 0) ? tx_q[0] : '0;
    end
  end

  // RX stream sink with back-pressure.
  initial forever begin
    @(posedge clk); #1;
    if (rx_valid && rx_stall > 0) begin rx_ready = 1'b0; rx_stall--; end
    else rx_ready = 1'b1;
  end

  always @(negedge clk) begin
    if (rx_valid && rx_ready) begin
      if (rx_exp.size() == 0) chk(0, "R4", "unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = rx_exp.pop_front();
        chk(rx_data == e, "R4", "rx byte", rx_data, e);
      end
    end
    if (ev_start) n_start++;
    if (ev_byte) n_byte++;
    if (ev_ack_err) n_err++;
    if (ev_arb_lost) n_arb++;
    if (ev_stop_done) n_stop++;
    if (ev_end) n_end++;
  end

  task automatic put_cmd(int idx, logic [2:0] opc, bit av, bit ae, bit ac, int cnt);
    @(posedge clk); #1;
    cmd_we = 1'b1; cmd_widx = idx[3:0]; cmd_wdata = {opc, av, ae, ac, cnt[7:0]};
    @(posedge clk); #1;
    cmd_we = 1'b0;
  endtask

  task automatic pulse_go();
    @(posedge clk); #1 go = 1'b1;
    @(posedge clk); #1 go = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic exp_start(); exp_ops.push_back(3'b000); endtask
  task automatic exp_stop();  exp_ops.push_back(3'b010); endtask

  task automatic exp_wbyte(logic [7:0] b, bit lsb, bit slave_ack);
    tx_q.push_back(b);
    for (int i = 0; i < 8; i++) exp_ops.push_back({2'd2, lsb ? b[i] : b[7-i]});
    exp_ops.push_back(3'b110);
    rbits.push_back(slave_ack);
  endtask

  task automatic exp_rbyte(logic [7:0] b, bit lsb, bit ackv);
    for (int i = 0; i < 8; i++) begin
      exp_ops.push_back(3'b110);
      rbits.push_back(lsb ? b[i] : b[7-i]);
    end
    rx_exp.push_back(b);
    exp_ops.push_back({2'd2, ackv});
  endtask

  task automatic drained(string req);
    chk(exp_ops.size() == 0, req, "bus ops left", exp_ops.size(), 0);
    chk(rx_exp.size() == 0, req, "rx bytes left", rx_exp.size(), 0);
  endtask

  task automatic load_rw_prog();
    put_cmd(0, 3'd0, 0, 0, 0, 0);
    put_cmd(1, 3'd1, 0, 0, 1, 2);
    put_cmd(2, 3'd2, 0, 0, 0, 1);
    put_cmd(3, 3'd2, 1, 0, 0, 1);
    put_cmd(4, 3'd3, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b_s, b_b, b_e, b_a, b_p, b_n;
    repeat (3) @(negedge clk);
    chk(busy == 0 && bus_req == 0 && tx_ready == 0 && rx_valid == 0, "R1", "reset idle", busy, 0);
    chk(cmd_done == 0, "R6", "reset done flags", cmd_done, 0);
    rst_n = 1'b1;

    // MSB-first write/read program with stream stalls (R1 R2 R3 R4 R6 R7)
    cur_req = "R3";
    load_rw_prog();
    exp_start(); exp_wbyte(8'hA5, 0, 0); exp_wbyte(8'h3C, 0, 0);
    exp_rbyte(8'h96, 0, 0); exp_rbyte(8'hE1, 0, 1); exp_stop();
    b_s = n_start; b_b = n_byte; b_p = n_stop; b_e = n_err;
    tx_stall = 4; rx_stall = 5;
    pulse_go(); wait_idle();
    drained("R3");
    chk(n_start - b_s == 1, "R2", "start events", n_start - b_s, 1);
    chk(n_byte - b_b == 4, "R3", "byte events", n_byte - b_b, 4);
    chk(n_stop - b_p == 1, "R7", "stop events", n_stop - b_p, 1);
    chk(n_err == b_e, "R9", "no ack error", n_err - b_e, 0);
    chk(cmd_done == 16'h001F, "R6", "done flags", cmd_done, 16'h001F);

    // LSB-first orders, fresh run clears flags, go while busy ignored (R1 R4 R6 R7)
    cur_req = "R4";
    tx_lsb_first = 1'b1; rx_lsb_first = 1'b1;
    exp_start(); exp_wbyte(8'h1E, 1, 0); exp_wbyte(8'hC4, 1, 0);
    exp_rbyte(8'h2B, 1, 0); exp_rbyte(8'h70, 1, 1); exp_stop();
    b_s = n_start; rx_stall = 3;
    pulse_go();
    @(negedge clk);
    chk(cmd_done == 0, "R6", "flags cleared on fresh run", cmd_done, 0);
    repeat (20) @(negedge clk);
    pulse_go();
    wait_idle();
    drained("R1");
    chk(n_start - b_s == 1, "R1", "go while busy ignored", n_start - b_s, 1);
    chk(cmd_done == 16'h001F, "R7", "done after stop", cmd_done, 16'h001F);

    // End entry and resume (R8 R6)
    cur_req = "R8";
    tx_lsb_first = 1'b0; rx_lsb_first = 1'b0;
    put_cmd(0, 3'd0, 0, 0, 0, 0);
    put_cmd(1, 3'd1, 0, 0, 1, 1);
    put_cmd(2, 3'd4, 0, 0, 0, 0);
    put_cmd(3, 3'd1, 0, 0, 1, 1);
    put_cmd(4, 3'd3, 0, 0, 0, 0);
    @(negedge clk);
    chk(cmd_done == 0, "R6", "rewrite clears flags", cmd_done, 0);
    exp_start(); exp_wbyte(8'h55, 0, 0);
    b_n = n_end; b_p = n_stop;
    pulse_go(); wait_idle();
    drained("R8");
    chk(n_end - b_n == 1, "R8", "end event", n_end - b_n, 1);
    chk(n_stop == b_p, "R8", "no stop before end", n_stop - b_p, 0);
    chk(cmd_done == 16'h0007, "R8", "flags at end", cmd_done, 16'h0007);
    exp_wbyte(8'hAA, 0, 0); exp_stop();
    b_s = n_start;
    pulse_go(); wait_idle();
    drained("R8");
    chk(n_start == b_s, "R8", "resume skips entry 0", n_start - b_s, 0);
    chk(cmd_done == 16'h001F, "R8", "flags kept on resume", cmd_done, 16'h001F);

    // Zero byte counts (R5)
    cur_req = "R5";
    put_cmd(1, 3'd1, 0, 0, 1, 0);
    put_cmd(2, 3'd2, 0, 0, 0, 0);
    put_cmd(3, 3'd3, 0, 0, 0, 0);
    exp_start(); exp_stop();
    b_b = n_byte;
    pulse_go(); wait_idle();
    drained("R5");
    chk(n_byte == b_b, "R5", "no byte events", n_byte - b_b, 0);
    chk(cmd_done == 16'h000F, "R5", "empty entries done", cmd_done, 16'h000F);

    // ACK mismatch with checking on, then off (R9)
    cur_req = "R9";
    put_cmd(1, 3'd1, 0, 0, 1, 2);
    put_cmd(2, 3'd3, 0, 0, 0, 0);
    exp_start(); exp_wbyte(8'hC3, 0, 1); exp_stop();
    b_e = n_err; b_p = n_stop; b_b = n_byte;
    pulse_go(); wait_idle();
    drained("R9");
    chk(n_err - b_e == 1, "R9", "ack error event", n_err - b_e, 1);
    chk(n_byte - b_b == 1, "R9", "byte event with error", n_byte - b_b, 1);
    chk(n_stop == b_p, "R9", "abort stop not a completion", n_stop - b_p, 0);
    chk(cmd_done == 16'h0001, "R9", "failed entry not done", cmd_done, 16'h0001);
    put_cmd(1, 3'd1, 0, 0, 0, 1);
    exp_start(); exp_wbyte(8'h3A, 0, 1); exp_stop();
    b_e = n_err;
    pulse_go(); wait_idle();
    drained("R9");
    chk(n_err == b_e, "R9", "unchecked nack ignored", n_err - b_e, 0);
    chk(cmd_done == 16'h0007, "R9", "unchecked run done", cmd_done, 16'h0007);

    // Lost bus on the third data bit (R10)
    cur_req = "R10";
    put_cmd(1, 3'd1, 0, 0, 1, 1);
    tx_q.push_back(8'hF0);
    exp_start();
    exp_ops.push_back(3'b101); exp_ops.push_back(3'b101); exp_ops.push_back(3'b101);
    lost_at = op_idx + 3;
    b_a = n_arb; b_p = n_stop;
    pulse_go(); wait_idle();
    lost_at = -1;
    drained("R10");
    chk(n_arb - b_a == 1, "R10", "arb lost event", n_arb - b_a, 1);
    chk(n_stop == b_p, "R10", "no stop after loss", n_stop - b_p, 0);
    chk(cmd_done == 16'h0001, "R10", "flags after loss", cmd_done, 16'h0001);
    chk(busy == 0 && bus_req == 0, "R10", "idle after loss", busy, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule